// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Frozen User Copy

This block keeps wall-clock time in packed BCD, from hundredths of a second up to a two-digit year. It has a century flag that can optionally flip when the year wraps. There are two copies of the eight time registers. The running copy is advanced by a tick-enable input. The user copy is what a host reads and writes through a byte-wide register port.

All eight user bytes are refreshed from the running copy in a single clock, whenever a transfer is allowed. A transfer is held off in three cases:

- while the host has the chip selected with its pointer on a time register;
- while a write to the time registers has not yet been committed;
- while the halt flag is set.

The halt flag is raised by a power-fail input. A host can then read the exact time at which power was lost.

Host writes land in the user copy. They are copied into the running counters when the chip select is released or when the auto-incrementing pointer leaves the time window. That copy also restarts the sub-hundredth prescaler. A stop flag in the seconds byte halts counting. A binary control byte is also provided; it is stored and read back only.

Top module: `rtc_bcd_keeper`

## Requirements
- R1: After reset the time bytes at 00h..07h read 00h, 00h, 00h, 00h, 01h, 01h, 01h, 00h. The control byte (08h) and the flag byte (0Ch) read 00h.
- R2: The hundredths byte advances once per TICKS_PER_HSEC pulses of `tick_en`. Each carry ripples through hundredths (00..99), seconds (bits 6:0, 00..59), minutes (00..59) and 24-hour hours (byte 03h bits 5:0, 00..23), all in BCD.
- R3: At midnight, the date (05h) rolls to 01h after the last day of the month in 06h, and the month then advances (01h..12h). Month lengths are 30 days for months 04h, 06h, 09h and 11h, and 31 days for the other months except February. February has 29 days when the BCD year in 07h, taken as a number, is a multiple of 4, and 28 days otherwise.
- R4: Day of week sits in bits 2:0 of byte 04h. It counts 1..7 at each midnight and wraps from 7 to 1.
- R5: Bit 7 of byte 03h enables the century flag in bit 6 of the same byte. When the year wraps from 99h to 00h, the flag inverts if the enable is 1 and holds if it is 0.
- R6: Bit 7 of byte 01h is a stop flag. While it is 1 in the running copy, no time byte changes. After it is cleared, counting resumes within TICKS_PER_HSEC ticks.
- R7: A write to address 00h stores 00h whatever data is given.
- R8: While `cs` is high and the pointer is in 00h..07h, the user copy changes only by host writes. A read therefore returns stable data.
- R9: A write into 00h..07h is held in the user copy without a transfer. It is loaded into the running copy in the first cycle in which the pointer is outside 00h..07h, or in which `cs` is low. That load also restarts the prescaler.
- R10: In the first cycle of `cs` high, the access address is `addr`. Each `rd` or `wr` strobe uses the current pointer and then increments it. `rdata` shows the read byte from the cycle after the `rd` strobe.
- R11: Address 08h is a plain 8-bit control byte that reads back what was written and touches no time byte. Addresses 09h..0Bh and 0Dh..0Fh read 00h and ignore writes.
- R12: The halt flag is bit 6 of the flag byte at 0Ch. `pwr_fail` high sets it, and a write of 0 to bit 6 clears it. While it is set, the user copy keeps the time of the power failure and the running copy keeps counting. After it is cleared, all eight user bytes show the running time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescaler tick; TICKS_PER_HSEC pulses make one hundredth |
| pwr_fail | input | 1 | Power-failure indication; sets the halt flag |
| cs | input | 1 | Register port select; rising edge loads the pointer |
| addr | input | ADDR_W | Start address of an access burst |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe (takes priority over `rd`) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
On every cycle, the embedded properties check four things:

- the user copy is frozen while a read sits in the time window and while the halt flag is set;
- a forced-zero hundredths write lands as 00h;
- the running copy moves only on a prescaler step, and never while stopped;
- a commit delivers exactly the user copy to the running counters, and the prescaler restarts.

Calendar arithmetic needs the bench scenarios, checked against its own model: month lengths, leap February, day-of-week wrap and the century flag. The same holds for pointer bursts that cross out of the time window, for the observable effect of the prescaler restart, and for the release of the halt freeze.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NREG     = 8;
  localparam int IDX_W    = $clog2(NREG);
  localparam int R_HSEC   = 0;
  localparam int R_SEC    = 1;
  localparam int R_MIN    = 2;
  localparam int R_HOUR   = 3;
  localparam int R_DOW    = 4;
  localparam int R_DATE   = 5;
  localparam int R_MON    = 6;
  localparam int R_YEAR   = 7;
  localparam int A_CTRL   = 8;
  localparam int A_FLAG   = 12;
  localparam int STOP_BIT = 7;
  localparam int CEN_BIT  = 7;
  localparam int CENT_BIT = 6;
  localparam int HALT_BIT = 6;

  typedef logic [7:0] byte_t;
  typedef logic [NREG-1:0][7:0] bank_t;

  // index 7 (year) first
  localparam bank_t BANK_RESET = {8'h00, 8'h01, 8'h01, 8'h01,
                                  8'h00, 8'h00, 8'h00, 8'h00};

  function automatic byte_t bcd_inc(input byte_t v);
    if (v[3:0] >= 4'h9) return {v[7:4] + 4'd1, 4'h0};
    return v + 8'd1;
  endfunction

  // BCD year is a multiple of four when (2*tens + units) mod 4 == 0
  function automatic logic bcd_leap(input byte_t yr);
    logic [4:0] s;
    s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic byte_t month_last(input byte_t mon, input byte_t yr);
    case (mon)
      8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic clr,
  output logic step
);
  generate
    if (DIV <= 1) begin : g_direct
      assign step = tick_en && !clr;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] TOP = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      assign step = tick_en && !clr && (cnt == TOP);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (tick_en) cnt <= (cnt == TOP) ? '0 : cnt + CW'(1);
      end

      // a cleared prescaler cannot step on the very next tick
      p_div_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !step);
    end
  endgenerate
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  load,
  input  bank_t load_val,
  output bank_t live
);
  bank_t nx;
  logic  cy;
  byte_t last_day;

  always_comb begin
    nx       = live;
    cy       = 1'b0;
    last_day = month_last(live[R_MON], live[R_YEAR]);
    if (load) begin
      nx = load_val;
    end else if (step && !live[R_SEC][STOP_BIT]) begin
      cy = 1'b1;
      if (live[R_HSEC] >= 8'h99) nx[R_HSEC] = 8'h00;
      else begin nx[R_HSEC] = bcd_inc(live[R_HSEC]); cy = 1'b0; end
      if (cy) begin
        if (live[R_SEC][6:0] >= 7'h59) nx[R_SEC] = 8'h00;
        else begin nx[R_SEC] = bcd_inc(live[R_SEC]); cy = 1'b0; end
      end
      if (cy) begin
        if (live[R_MIN] >= 8'h59) nx[R_MIN] = 8'h00;
        else begin nx[R_MIN] = bcd_inc(live[R_MIN]); cy = 1'b0; end
      end
      if (cy) begin
        if (live[R_HOUR][5:0] >= 6'h23) begin
          nx[R_HOUR][5:0] = 6'h00;
        end else begin
          if (live[R_HOUR][3:0] >= 4'h9)
            nx[R_HOUR][5:0] = {live[R_HOUR][5:4] + 2'd1, 4'h0};
          else
            nx[R_HOUR][3:0] = live[R_HOUR][3:0] + 4'd1;
          cy = 1'b0;
        end
      end
      if (cy) begin
        if (live[R_DOW][2:0] >= 3'd7 || live[R_DOW][2:0] == 3'd0) nx[R_DOW] = 8'h01;
        else nx[R_DOW] = {5'b0, live[R_DOW][2:0] + 3'd1};
        if (live[R_DATE] >= last_day) nx[R_DATE] = 8'h01;
        else begin nx[R_DATE] = bcd_inc(live[R_DATE]); cy = 1'b0; end
      end
      if (cy) begin
        if (live[R_MON] >= 8'h12) nx[R_MON] = 8'h01;
        else begin nx[R_MON] = bcd_inc(live[R_MON]); cy = 1'b0; end
      end
      if (cy) begin
        if (live[R_YEAR] >= 8'h99) begin
          nx[R_YEAR] = 8'h00;
          if (live[R_HOUR][CEN_BIT]) nx[R_HOUR][CENT_BIT] = ~live[R_HOUR][CENT_BIT];
        end else begin
          nx[R_YEAR] = bcd_inc(live[R_YEAR]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= BANK_RESET;
    else        live <= nx;
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> (live == $past(live)));

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live[R_SEC][STOP_BIT] && !load) |=> (live == $past(live)));
endmodule

// File: rtl/rtc_access.sv
module rtc_access
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic              pwr_fail,
  input  bank_t             live,
  output logic [7:0]        rdata,
  output logic              commit,
  output bank_t             shadow
);
  localparam logic [ADDR_W-1:0] LAST_CLK = ADDR_W'(NREG - 1);
  localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] FLAG_A   = ADDR_W'(A_FLAG);

  logic              cs_q, dirty, halt, in_win, xfer, rd_acc, wr_acc, strobe;
  logic [ADDR_W-1:0] ptr, cur;
  byte_t             ctrl, rd_val;

  assign cur    = (cs && !cs_q) ? addr : ptr;
  assign wr_acc = cs && wr;
  assign rd_acc = cs && rd && !wr;
  assign strobe = wr_acc || rd_acc;
  assign in_win = cs && (cur <= LAST_CLK);
  assign commit = dirty && !in_win;
  assign xfer   = !halt && !in_win && !dirty;

  always_comb begin
    rd_val = '0;
    if (cur <= LAST_CLK)  rd_val = shadow[cur[IDX_W-1:0]];
    else if (cur == CTRL_A) rd_val = ctrl;
    else if (cur == FLAG_A) rd_val[HALT_BIT] = halt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      ptr    <= '0;
      dirty  <= 1'b0;
      halt   <= 1'b0;
      ctrl   <= '0;
      rdata  <= '0;
      shadow <= BANK_RESET;
    end else begin
      cs_q <= cs;
      if (cs) ptr <= cur + {{(ADDR_W-1){1'b0}}, strobe};
      if (wr_acc && cur <= LAST_CLK) dirty <= 1'b1;
      else if (commit)               dirty <= 1'b0;
      if (xfer) shadow <= live;
      else if (wr_acc && cur <= LAST_CLK)
        shadow[cur[IDX_W-1:0]] <= (cur == '0) ? 8'h00 : wdata;
      if (wr_acc && cur == CTRL_A) ctrl <= wdata;
      if (pwr_fail)                       halt <= 1'b1;
      else if (wr_acc && cur == FLAG_A)   halt <= wdata[HALT_BIT];
      if (rd_acc) rdata <= rd_val;
    end
  end

  p_read_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !wr_acc) |=> (shadow == $past(shadow)));

  p_halt_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_acc) |=> (shadow == $past(shadow)));

  p_pwrfail_halt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> halt);

  p_hsec_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && cur == '0) |=> (shadow[R_HSEC] == 8'h00));
endmodule

// File: rtl/rtc_bcd_keeper.sv
module rtc_bcd_keeper
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_HSEC = 2,
  parameter int ADDR_W         = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              pwr_fail,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  bank_t live, shadow;
  logic  commit, step;

  rtc_divider #(.DIV(TICKS_PER_HSEC)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .clr(commit || live[R_SEC][STOP_BIT]), .step(step)
  );

  rtc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load(commit),
    .load_val(shadow), .live(live)
  );

  rtc_access #(.ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .pwr_fail(pwr_fail), .live(live), .rdata(rdata),
    .commit(commit), .shadow(shadow)
  );

  p_commit_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (live == $past(shadow)));
endmodule

// File: tb/rtc_bcd_keeper_test.sv
module rtc_bcd_keeper_test;
  localparam int CLK_PERIOD = 10;
  localparam int TPH        = 2;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, pwr_fail = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int m_hs = 0, m_s = 0, m_mi = 0, m_h = 0, m_dw = 1, m_dt = 1, m_mo = 1, m_yr = 0;
  bit m_stop = 0, m_ce = 0, m_cb = 0;
  logic [7:0] got  [16];
  logic [7:0] wbuf [16];
  logic [7:0] snap [8];

  rtc_bcd_keeper #(.TICKS_PER_HSEC(TPH), .ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwr_fail(pwr_fail),
    .cs(cs), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int days_in(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function logic [7:0] exp_byte(input int i);
    case (i)
      0: return to_bcd(m_hs);
      1: return {m_stop, 7'(to_bcd(m_s))};
      2: return to_bcd(m_mi);
      3: return {m_ce, m_cb, 6'(to_bcd(m_h))};
      4: return 8'(m_dw);
      5: return to_bcd(m_dt);
      6: return to_bcd(m_mo);
      default: return to_bcd(m_yr);
    endcase
  endfunction

  task automatic step_model();
    if (m_stop) return;
    m_hs++;
    if (m_hs < 100) return;
    m_hs = 0; m_s++;
    if (m_s < 60) return;
    m_s = 0; m_mi++;
    if (m_mi < 60) return;
    m_mi = 0; m_h++;
    if (m_h < 24) return;
    m_h = 0;
    m_dw = (m_dw == 7) ? 1 : m_dw + 1;
    m_dt++;
    if (m_dt <= days_in(m_mo, m_yr)) return;
    m_dt = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_yr++;
    if (m_yr < 100) return;
    m_yr = 0;
    if (m_ce) m_cb = ~m_cb;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic run_hs(input int n);
    for (int k = 0; k < n; k++) begin
      for (int d = 0; d < TPH; d++) begin
        @(negedge clk) tick_en = 1'b1;
      end
      step_model();
    end
    @(negedge clk) tick_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic write_burst(input logic [3:0] a, input int n);
    @(negedge clk) begin cs = 1'b1; addr = a; wr = 1'b1; wdata = wbuf[0]; end
    for (int i = 1; i < n; i++) begin
      @(negedge clk) wdata = wbuf[i];
    end
    @(negedge clk) begin wr = 1'b0; cs = 1'b0; end
    repeat (2) @(negedge clk);
  endtask

  task automatic read_burst(input logic [3:0] a, input int n);
    @(negedge clk) begin cs = 1'b1; addr = a; rd = 1'b1; end
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin
        got[i] = rdata;
        if (i == n - 1) begin rd = 1'b0; cs = 1'b0; end
      end
    end
    @(negedge clk);
  endtask

  task automatic check_bank(input string tag);
    read_burst(4'h0, 8);
    for (int i = 0; i < 8; i++) check(tag, got[i], exp_byte(i));
  endtask

  task automatic set_time(input int s, input int mi, input int h, input int dw,
                          input int dt, input int mo, input int yr,
                          input bit ce, input bit cb);
    m_hs = 0; m_s = s; m_mi = mi; m_h = h; m_dw = dw; m_dt = dt;
    m_mo = mo; m_yr = yr; m_ce = ce; m_cb = cb; m_stop = 0;
    for (int i = 0; i < 8; i++) wbuf[i] = exp_byte(i);
    write_burst(4'h0, 8);
  endtask

  initial begin
    wait (cyc >= WATCHDOG);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10: reset image through a burst read
    check_bank("R1 reset bank");
    read_burst(4'h8, 1); check("R1 ctrl reset", got[0], 8'h00);
    read_burst(4'hC, 1); check("R1 flag reset", got[0], 8'h00);

    // R7: hundredths write forced to 00
    m_hs = 0; m_s = 12; m_mi = 34; m_h = 5; m_dw = 3; m_dt = 9; m_mo = 7; m_yr = 41;
    for (int i = 0; i < 8; i++) wbuf[i] = exp_byte(i);
    wbuf[0] = 8'h42;
    write_burst(4'h0, 8);
    read_burst(4'h0, 1); check("R7 hsec forced", got[0], 8'h00);
    check_bank("R10 burst readback");

    // R2: carries into hours
    set_time(59, 59, 9, 2, 10, 3, 15, 0, 0);
    run_hs(100); check_bank("R2 carry to hour 10");
    run_hs(257); check_bank("R2 partial seconds");

    // R3 / R4: month lengths, leap year, day-of-week wrap
    set_time(59, 59, 23, 7, 28, 2, 24, 0, 0);
    run_hs(100); check_bank("R3 leap Feb 29 / R4 dow wrap");
    set_time(59, 59, 23, 4, 28, 2, 23, 0, 0);
    run_hs(100); check_bank("R3 common Feb -> Mar 1");
    set_time(59, 59, 23, 6, 30, 4, 10, 0, 0);
    run_hs(100); check_bank("R3 Apr 30 -> May 1");

    // R5: century flag with and without enable
    set_time(59, 59, 23, 5, 31, 12, 99, 1, 0);
    run_hs(100); check_bank("R5 century toggles");
    read_burst(4'h3, 1); check("R5 hour byte", got[0], 8'hC0);
    set_time(59, 59, 23, 5, 31, 12, 99, 0, 1);
    run_hs(100); check_bank("R5 century holds");

    // R6: stop and resume
    set_time(20, 1, 2, 1, 3, 4, 5, 0, 0);
    run_hs(37);
    wbuf[0] = 8'h80 | to_bcd(m_s); write_burst(4'h1, 1); m_stop = 1;
    run_hs(100); check_bank("R6 stopped");
    wbuf[0] = to_bcd(m_s); write_burst(4'h1, 1); m_stop = 0;
    run_hs(50); check_bank("R6 resumed");

    // R8: user copy frozen while reading inside the window
    set_time(59, 10, 8, 2, 5, 6, 30, 0, 0);
    for (int i = 0; i < 8; i++) snap[i] = exp_byte(i);
    @(negedge clk) begin cs = 1'b1; addr = 4'h1; rd = 1'b1; end
    @(negedge clk) begin rd = 1'b0; check("R8 first read", rdata, snap[1]); end
    for (int k = 0; k < 100; k++) begin
      for (int d = 0; d < TPH; d++) begin
        @(negedge clk) tick_en = 1'b1;
      end
      step_model();
    end
    @(negedge clk) tick_en = 1'b0;
    repeat (2) @(negedge clk);
    rd = 1'b1;
    @(negedge clk) begin rd = 1'b0; check("R8 frozen minute", rdata, snap[2]); end
    @(negedge clk) cs = 1'b0;
    repeat (2) @(negedge clk);
    check_bank("R8 released");

    // R9 / R11: burst crosses out of the window into the control byte
    set_time(1, 2, 3, 4, 20, 5, 50, 0, 0);
    m_mo = 11; m_yr = 77;
    wbuf[0] = to_bcd(m_mo); wbuf[1] = to_bcd(m_yr); wbuf[2] = 8'h5A;
    write_burst(4'h6, 3);
    check_bank("R9 commit past window");
    read_burst(4'h8, 1); check("R11 ctrl readback", got[0], 8'h5A);
    wbuf[0] = 8'hFF; write_burst(4'hA, 1);
    read_burst(4'hA, 1); check("R11 unmapped reads zero", got[0], 8'h00);
    check_bank("R11 time untouched");

    // R9: prescaler restart on commit
    run_hs(13);
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
    m_mi = 44; wbuf[0] = to_bcd(m_mi); write_burst(4'h2, 1);
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
    repeat (2) @(negedge clk);
    check_bank("R9 divider restarted");
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
    step_model();
    repeat (2) @(negedge clk);
    check_bank("R9 step after restart");

    // R12: halt on power fail, release by software
    set_time(30, 45, 12, 3, 14, 8, 62, 0, 0);
    run_hs(21);
    @(negedge clk) pwr_fail = 1'b1;
    @(negedge clk) pwr_fail = 1'b0;
    for (int i = 0; i < 8; i++) snap[i] = exp_byte(i);
    run_hs(150);
    read_burst(4'h0, 8);
    for (int i = 0; i < 8; i++) check("R12 frozen at power fail", got[i], snap[i]);
    read_burst(4'hC, 1); check("R12 halt flag", got[0], 8'h40);
    wbuf[0] = 8'h00; write_burst(4'hC, 1);
    check_bank("R12 released");
    read_burst(4'hC, 1); check("R12 halt cleared", got[0], 8'h00);

    // R2 / R3 / R4: random valid times and run lengths
    for (int it = 0; it < 20; it++) begin
      int yr, mo;
      yr = int'($urandom_range(0, 99));
      mo = int'($urandom_range(1, 12));
      set_time(int'($urandom_range(0, 59)), int'($urandom_range(0, 59)),
               int'($urandom_range(0, 23)), int'($urandom_range(1, 7)),
               int'($urandom_range(1, days_in(mo, yr))), mo, yr,
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      run_hs(int'($urandom_range(0, 500)));
      check_bank("R2 random run");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule